// File: doc/BRIEF.md
# Local-Bus-to-PCI Write Response Controller

This block is the write side of a bridge from a processor local bus to PCI. A local-bus master hands it one single write of one to four bytes. The controller turns that write into a PCI master write cycle. How it completes the local-bus side depends on the target address space.

Memory and I/O writes are posted. They are stored in a two-entry write buffer and acknowledged at once. The buffer then drains to PCI in arrival order. If PCI asks for a retry or a disconnect, the same entry is requested and issued again.

Configuration and special-cycle writes are not posted. The controller holds the local bus in a wait state and issues the write only after every posted write ahead of it has drained. It then answers the local bus with one of three results:
- a plain completion,
- a completion flagged as a master error,
- a request to rearbitrate.

On the PCI side the bus is seen as three handshakes: a request, a grant and a one-cycle response code. Burst and line writes are not handled and produce no action at all.

Top module: `lbpci_wr_ctrl`

## Requirements
- R1: While reset is held, lb_ack, lb_wait, lb_merr, lb_rearb, pci_req and pci_frame are all low.
- R2: A single write (lb_kind 0) to memory (lb_space 0) or I/O (lb_space 1) that is sampled in the idle state while a buffer entry is free is acknowledged exactly one cycle later, for one cycle, with lb_wait and lb_merr low. pci_req then rises in the following cycle.
- R3: Writes reach the PCI side in the order they were accepted. Address, data, byte enables and space are carried unchanged. The buffer never exceeds two entries.
- R4: A posted write that receives retry (pci_rsp 1) or disconnect (pci_rsp 2) keeps its buffer entry and is requested and issued again.
- R5: A posted write that receives accept (pci_rsp 0) frees its entry. A posted write that receives master abort (3) or target abort (4) also frees its entry, and nothing is reported on the local bus.
- R6: A single configuration (lb_space 2) or special-cycle (lb_space 3) write raises lb_wait one cycle after it is sampled, and is not acknowledged while its PCI cycle is pending. Its PCI cycle starts only when the write buffer is empty.
- R7: A waited write answered with accept or disconnect is acknowledged one cycle after the response, with lb_merr low.
- R8: A waited write answered with retry produces a one-cycle lb_rearb pulse, with no lb_ack, one cycle after the response, and lb_wait drops.
- R9: A waited write answered with master or target abort is acknowledged one cycle after the response, with lb_merr high.
- R10: A memory or I/O write that arrives while the buffer is full holds lb_wait until an entry frees. It is then buffered and acknowledged, and it is not lost.
- R11: Burst (lb_kind 1) and line (lb_kind 2) writes are ignored: no lb_ack, no lb_wait and no PCI request.
- R12: The local-bus master keeps lb_req high whenever lb_wait is high. It withdraws a request only after lb_ack or lb_rearb, or when the request was never taken up.
- R13: pci_frame rises only after a cycle with pci_gnt high. Address, data, byte enables and space stay stable while pci_frame waits for its response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_req | input | 1 | Local-bus write request, held until answered |
| lb_kind | input | 2 | Transfer kind: 0 single, 1 burst, 2 line |
| lb_space | input | 2 | Address space: 0 memory, 1 I/O, 2 configuration, 3 special cycle |
| lb_addr | input | AW | Write address |
| lb_wdata | input | DW | Write data |
| lb_be | input | DW/8 | Byte enables |
| lb_ack | output | 1 | One-cycle completion of the local-bus write |
| lb_wait | output | 1 | Local bus held in a wait state |
| lb_merr | output | 1 | Master error, valid with lb_ack |
| lb_rearb | output | 1 | One-cycle rearbitrate indication |
| pci_req | output | 1 | PCI bus request |
| pci_gnt | input | 1 | PCI bus grant |
| pci_frame | output | 1 | PCI write cycle in progress, fields valid |
| pci_addr | output | AW | PCI address |
| pci_data | output | DW | PCI data |
| pci_be | output | DW/8 | PCI byte enables |
| pci_space | output | 2 | Address space of the PCI cycle |
| pci_rsp_vld | input | 1 | PCI response valid (one cycle) |
| pci_rsp | input | 3 | Response: 0 accept, 1 retry, 2 disconnect, 3 master abort, 4 target abort |

## Verification
A posted write is acknowledged in the first cycle after its request is sampled. pci_req follows one cycle later. The frame comes one cycle after the grant is sampled. A waited write's acknowledge, error flag or rearbitrate pulse appears one cycle after the response is sampled.

The bench drives every input on the falling edge and reads outputs on the falling edge. It checks the posted acknowledge and the lb_wait rise at exactly the next falling edge. It checks the waited-write answer by comparing the cycle counter at the answer against the cycle in which the monitor returned the PCI response.

A scoreboard queue, filled by the driver tasks in acceptance order, is compared with each PCI frame. This checks ordering, field integrity and re-issue after retry.

// File: rtl/lbpci_pkg.sv
package lbpci_pkg;

    typedef enum logic [1:0] {
        SP_MEM  = 2'd0,
        SP_IO   = 2'd1,
        SP_CFG  = 2'd2,
        SP_SPEC = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        K_SINGLE = 2'd0,
        K_BURST  = 2'd1,
        K_LINE   = 2'd2,
        K_RSVD   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        RSP_ACCEPT = 3'd0,
        RSP_RETRY  = 3'd1,
        RSP_DISC   = 3'd2,
        RSP_MABORT = 3'd3,
        RSP_TABORT = 3'd4
    } rsp_e;

    // Memory and I/O writes complete early; the other two spaces are held.
    function automatic logic space_posted(input logic [1:0] sp);
        return (sp == SP_MEM) || (sp == SP_IO);
    endfunction

    function automatic logic rsp_is_abort(input logic [2:0] r);
        return (r == RSP_MABORT) || (r == RSP_TABORT);
    endfunction

endpackage

// File: rtl/lbpci_wbuf.sv
module lbpci_wbuf #(
    parameter int W     = 68,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } wbuf_t;

    wbuf_t buf_d, buf_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        buf_d = buf_q;
        if (push) begin
            buf_d.mem[buf_q.wr] = push_data;
            buf_d.wr            = ptr_next(buf_q.wr);
        end
        if (pop) begin
            buf_d.rd = ptr_next(buf_q.rd);
        end
        buf_d.cnt = buf_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign head  = buf_q.mem[buf_q.rd];
    assign full  = (buf_q.cnt == CNT_W'(DEPTH));
    assign empty = (buf_q.cnt == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/lbpci_lb_front.sv
module lbpci_lb_front
    import lbpci_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lb_req,
    input  logic [1:0]     lb_kind,
    input  logic [1:0]     lb_space,
    input  logic [AW-1:0]  lb_addr,
    input  logic [DW-1:0]  lb_wdata,
    input  logic [BEW-1:0] lb_be,
    output logic           lb_ack,
    output logic           lb_wait,
    output logic           lb_merr,
    output logic           lb_rearb,
    input  logic           buf_full,
    output logic           buf_push,
    output logic [AW-1:0]  push_addr,
    output logic [DW-1:0]  push_data,
    output logic [BEW-1:0] push_be,
    output logic [1:0]     push_space,
    output logic           np_valid,
    output logic [AW-1:0]  np_addr,
    output logic [DW-1:0]  np_data,
    output logic [BEW-1:0] np_be,
    output logic [1:0]     np_space,
    input  logic           np_done,
    input  logic [2:0]     np_rsp
);
    typedef enum logic [1:0] {L_IDLE, L_FULL, L_NP, L_RESP} lst_e;

    typedef struct packed {
        lst_e           st;
        logic           ack;
        logic           merr;
        logic           rearb;
        logic           wt;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BEW-1:0] be;
        logic [1:0]     sp;
    } lfront_t;

    lfront_t fr_d, fr_q;
    logic    from_held;
    logic    take_single;

    assign take_single = lb_req && (lb_kind == K_SINGLE);

    always_comb begin
        fr_d      = fr_q;
        buf_push  = 1'b0;
        from_held = 1'b0;
        unique case (fr_q.st)
            L_IDLE: begin
                if (take_single) begin
                    fr_d.addr = lb_addr;
                    fr_d.data = lb_wdata;
                    fr_d.be   = lb_be;
                    fr_d.sp   = lb_space;
                    if (space_posted(lb_space)) begin
                        if (!buf_full) begin
                            buf_push = 1'b1;
                            fr_d.ack = 1'b1;
                            fr_d.st  = L_RESP;
                        end else begin
                            fr_d.wt = 1'b1;
                            fr_d.st = L_FULL;
                        end
                    end else begin
                        fr_d.wt = 1'b1;
                        fr_d.st = L_NP;
                    end
                end
            end
            L_FULL: begin
                if (!buf_full) begin
                    buf_push  = 1'b1;
                    from_held = 1'b1;
                    fr_d.wt   = 1'b0;
                    fr_d.ack  = 1'b1;
                    fr_d.st   = L_RESP;
                end
            end
            L_NP: begin
                if (np_done) begin
                    fr_d.wt = 1'b0;
                    fr_d.st = L_RESP;
                    if (np_rsp == RSP_RETRY) begin
                        fr_d.rearb = 1'b1;
                    end else begin
                        fr_d.ack  = 1'b1;
                        fr_d.merr = rsp_is_abort(np_rsp);
                    end
                end
            end
            default: begin
                fr_d.ack   = 1'b0;
                fr_d.merr  = 1'b0;
                fr_d.rearb = 1'b0;
                fr_d.st    = L_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign push_addr  = from_held ? fr_q.addr : lb_addr;
    assign push_data  = from_held ? fr_q.data : lb_wdata;
    assign push_be    = from_held ? fr_q.be   : lb_be;
    assign push_space = from_held ? fr_q.sp   : lb_space;

    assign np_valid = (fr_q.st == L_NP);
    assign np_addr  = fr_q.addr;
    assign np_data  = fr_q.data;
    assign np_be    = fr_q.be;
    assign np_space = fr_q.sp;

    assign lb_ack   = fr_q.ack;
    assign lb_wait  = fr_q.wt;
    assign lb_merr  = fr_q.merr;
    assign lb_rearb = fr_q.rearb;

    assert_posted_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == L_IDLE && take_single && space_posted(lb_space) && !buf_full)
        |=> lb_ack && !lb_wait && !lb_merr);
    assert_np_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == L_IDLE && take_single && !space_posted(lb_space))
        |=> lb_wait && !lb_ack);
    assert_np_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (np_done && (np_rsp == RSP_ACCEPT || np_rsp == RSP_DISC))
        |=> lb_ack && !lb_merr && !lb_rearb);
    assert_np_rearb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (np_done && np_rsp == RSP_RETRY) |=> lb_rearb && !lb_ack && !lb_wait);
    assert_np_merr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (np_done && rsp_is_abort(np_rsp)) |=> lb_ack && lb_merr);
    assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == L_FULL && buf_full) |=> lb_wait && !lb_ack);
    assert_ignore_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.st == L_IDLE && lb_req && lb_kind != K_SINGLE) |=> !lb_ack && !lb_wait);
    assert_master_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wait |-> lb_req);

endmodule

// File: rtl/lbpci_issue.sv
module lbpci_issue
    import lbpci_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           buf_empty,
    input  logic [AW-1:0]  hd_addr,
    input  logic [DW-1:0]  hd_data,
    input  logic [BEW-1:0] hd_be,
    input  logic [1:0]     hd_space,
    output logic           buf_pop,
    input  logic           np_valid,
    input  logic [AW-1:0]  np_addr,
    input  logic [DW-1:0]  np_data,
    input  logic [BEW-1:0] np_be,
    input  logic [1:0]     np_space,
    output logic           np_done,
    output logic [2:0]     np_rsp,
    output logic           pci_req,
    input  logic           pci_gnt,
    output logic           pci_frame,
    output logic [AW-1:0]  pci_addr,
    output logic [DW-1:0]  pci_data,
    output logic [BEW-1:0] pci_be,
    output logic [1:0]     pci_space,
    input  logic           pci_rsp_vld,
    input  logic [2:0]     pci_rsp
);
    typedef enum logic [1:0] {E_IDLE, E_REQ, E_XFER} est_e;

    typedef struct packed {
        est_e st;
        logic sel_np;
    } eng_t;

    eng_t en_d, en_q;

    always_comb begin
        en_d    = en_q;
        buf_pop = 1'b0;
        np_done = 1'b0;
        unique case (en_q.st)
            E_IDLE: begin
                // Posted entries always go first; a held write waits for an empty buffer.
                if (!buf_empty) begin
                    en_d.st     = E_REQ;
                    en_d.sel_np = 1'b0;
                end else if (np_valid) begin
                    en_d.st     = E_REQ;
                    en_d.sel_np = 1'b1;
                end
            end
            E_REQ: begin
                if (pci_gnt) en_d.st = E_XFER;
            end
            E_XFER: begin
                if (pci_rsp_vld) begin
                    if (en_q.sel_np) begin
                        np_done = 1'b1;
                        en_d.st = E_IDLE;
                    end else if (pci_rsp == RSP_RETRY || pci_rsp == RSP_DISC) begin
                        en_d.st = E_REQ;
                    end else begin
                        buf_pop = 1'b1;
                        en_d.st = E_IDLE;
                    end
                end
            end
            default: en_d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign np_rsp    = pci_rsp;
    assign pci_req   = (en_q.st == E_REQ);
    assign pci_frame = (en_q.st == E_XFER);
    assign pci_addr  = en_q.sel_np ? np_addr  : hd_addr;
    assign pci_data  = en_q.sel_np ? np_data  : hd_data;
    assign pci_be    = en_q.sel_np ? np_be    : hd_be;
    assign pci_space = en_q.sel_np ? np_space : hd_space;

    assert_frame_after_gnt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_frame) |-> $past(pci_gnt));
    assert_fields_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_frame && !pci_rsp_vld) |=>
        $stable(pci_addr) && $stable(pci_data) && $stable(pci_be) && $stable(pci_space));
    assert_np_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_req && en_q.sel_np) |-> buf_empty);
    assert_retry_reissue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_frame && pci_rsp_vld && !en_q.sel_np &&
         (pci_rsp == RSP_RETRY || pci_rsp == RSP_DISC)) |=> pci_req && !buf_empty);

endmodule

// File: rtl/lbpci_wr_ctrl.sv
module lbpci_wr_ctrl
    import lbpci_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_req,
    input  logic [1:0]        lb_kind,
    input  logic [1:0]        lb_space,
    input  logic [AW-1:0]     lb_addr,
    input  logic [DW-1:0]     lb_wdata,
    input  logic [DW/8-1:0]   lb_be,
    output logic              lb_ack,
    output logic              lb_wait,
    output logic              lb_merr,
    output logic              lb_rearb,
    output logic              pci_req,
    input  logic              pci_gnt,
    output logic              pci_frame,
    output logic [AW-1:0]     pci_addr,
    output logic [DW-1:0]     pci_data,
    output logic [DW/8-1:0]   pci_be,
    output logic [1:0]        pci_space,
    input  logic              pci_rsp_vld,
    input  logic [2:0]        pci_rsp
);
    localparam int BEW     = DW / 8;
    localparam int ENTRY_W = AW + DW + BEW + 2;

    logic               buf_push, buf_pop, buf_full, buf_empty;
    logic [ENTRY_W-1:0] buf_head;
    logic [AW-1:0]      push_addr, np_addr, hd_addr;
    logic [DW-1:0]      push_data, np_data, hd_data;
    logic [BEW-1:0]     push_be, np_be, hd_be;
    logic [1:0]         push_space, np_space, hd_space;
    logic               np_valid, np_done;
    logic [2:0]         np_rsp;

    assign {hd_addr, hd_data, hd_be, hd_space} = buf_head;

    lbpci_lb_front #(.AW(AW), .DW(DW), .BEW(BEW)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .lb_req     (lb_req),
        .lb_kind    (lb_kind),
        .lb_space   (lb_space),
        .lb_addr    (lb_addr),
        .lb_wdata   (lb_wdata),
        .lb_be      (lb_be),
        .lb_ack     (lb_ack),
        .lb_wait    (lb_wait),
        .lb_merr    (lb_merr),
        .lb_rearb   (lb_rearb),
        .buf_full   (buf_full),
        .buf_push   (buf_push),
        .push_addr  (push_addr),
        .push_data  (push_data),
        .push_be    (push_be),
        .push_space (push_space),
        .np_valid   (np_valid),
        .np_addr    (np_addr),
        .np_data    (np_data),
        .np_be      (np_be),
        .np_space   (np_space),
        .np_done    (np_done),
        .np_rsp     (np_rsp)
    );

    lbpci_wbuf #(.W(ENTRY_W), .DEPTH(DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (buf_push),
        .push_data ({push_addr, push_data, push_be, push_space}),
        .pop       (buf_pop),
        .head      (buf_head),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    lbpci_issue #(.AW(AW), .DW(DW), .BEW(BEW)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_empty   (buf_empty),
        .hd_addr     (hd_addr),
        .hd_data     (hd_data),
        .hd_be       (hd_be),
        .hd_space    (hd_space),
        .buf_pop     (buf_pop),
        .np_valid    (np_valid),
        .np_addr     (np_addr),
        .np_data     (np_data),
        .np_be       (np_be),
        .np_space    (np_space),
        .np_done     (np_done),
        .np_rsp      (np_rsp),
        .pci_req     (pci_req),
        .pci_gnt     (pci_gnt),
        .pci_frame   (pci_frame),
        .pci_addr    (pci_addr),
        .pci_data    (pci_data),
        .pci_be      (pci_be),
        .pci_space   (pci_space),
        .pci_rsp_vld (pci_rsp_vld),
        .pci_rsp     (pci_rsp)
    );

endmodule

// File: tb/lbpci_wr_ctrl_tb.sv
module lbpci_wr_ctrl_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BEW = DW / 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           lb_req = 1'b0;
    logic [1:0]     lb_kind = 2'd0;
    logic [1:0]     lb_space = 2'd0;
    logic [AW-1:0]  lb_addr = '0;
    logic [DW-1:0]  lb_wdata = '0;
    logic [BEW-1:0] lb_be = '0;
    logic           lb_ack, lb_wait, lb_merr, lb_rearb;
    logic           pci_req, pci_frame;
    logic           pci_gnt = 1'b0;
    logic [AW-1:0]  pci_addr;
    logic [DW-1:0]  pci_data;
    logic [BEW-1:0] pci_be;
    logic [1:0]     pci_space;
    logic           pci_rsp_vld = 1'b0;
    logic [2:0]     pci_rsp = 3'd0;

    always #2 clk = ~clk;

    lbpci_wr_ctrl #(.AW(AW), .DW(DW), .DEPTH(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lb_req(lb_req), .lb_kind(lb_kind), .lb_space(lb_space),
        .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_be(lb_be),
        .lb_ack(lb_ack), .lb_wait(lb_wait), .lb_merr(lb_merr), .lb_rearb(lb_rearb),
        .pci_req(pci_req), .pci_gnt(pci_gnt), .pci_frame(pci_frame),
        .pci_addr(pci_addr), .pci_data(pci_data), .pci_be(pci_be),
        .pci_space(pci_space), .pci_rsp_vld(pci_rsp_vld), .pci_rsp(pci_rsp)
    );

    typedef struct packed {
        logic [AW-1:0]  addr;
        logic [DW-1:0]  data;
        logic [BEW-1:0] be;
        logic [1:0]     sp;
    } item_t;

    item_t      exp_q[$];
    logic [2:0] rsp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    int n_frames = 0;
    int cyc = 0;
    int last_rsp_cyc = -10;
    bit hold_gnt = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // PCI-side model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            pci_rsp_vld = 1'b0;
            pci_gnt = pci_req && !hold_gnt;
            if (pci_frame) begin
                logic [2:0] code;
                item_t got, want;
                bit keep;
                n_frames++;
                got = '{addr: pci_addr, data: pci_data, be: pci_be, sp: pci_space};
                code = (rsp_q.size() > 0) ? rsp_q.pop_front() : 3'd0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected PCI frame", 128'(got), 128'(0));
                end else begin
                    want = exp_q[0];
                    check(got == want, "R3", "PCI frame fields/order", 128'(got), 128'(want));
                    keep = (pci_space < 2'd2) && (code == 3'd1 || code == 3'd2);
                    if (!keep) void'(exp_q.pop_front());
                end
                pci_rsp = code;
                pci_rsp_vld = 1'b1;
                last_rsp_cyc = cyc;
            end
        end
    end

    task automatic drop_req();
        lb_req = 1'b0;
        lb_kind = 2'd0;
    endtask

    task automatic drive(input logic [1:0] kind, input logic [1:0] sp, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [BEW-1:0] be);
        lb_req = 1'b1; lb_kind = kind; lb_space = sp;
        lb_addr = a; lb_wdata = d; lb_be = be;
    endtask

    // Posted write with a free entry: ack due at the very next falling edge.
    task automatic lb_post(input logic [1:0] sp, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [BEW-1:0] be);
        exp_q.push_back('{addr: a, data: d, be: be, sp: sp});
        @(negedge clk);
        drive(2'd0, sp, a, d, be);
        @(negedge clk);
        check(lb_ack && !lb_wait && !lb_merr && !lb_rearb, "R2", "posted ack one cycle after request",
              {lb_ack, lb_wait, lb_merr, lb_rearb}, 4'b1000);
        drop_req();
    endtask

    // Posted write that may wait for a free entry (R10).
    task automatic lb_post_full(input logic [1:0] sp, input logic [AW-1:0] a,
                                input logic [DW-1:0] d, input logic [BEW-1:0] be);
        bit seen = 1'b0;
        exp_q.push_back('{addr: a, data: d, be: be, sp: sp});
        @(negedge clk);
        drive(2'd0, sp, a, d, be);
        @(negedge clk);
        check(lb_wait && !lb_ack, "R10", "wait while buffer full", {lb_wait, lb_ack}, 2'b10);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (lb_ack) begin seen = 1'b1; break; end
        end
        check(seen && !lb_merr, "R10", "buffered after entry frees", {seen, lb_merr}, 2'b10);
        drop_req();
    endtask

    // Waited write; outcome 0 = ack, 1 = rearbitrate, 2 = ack with error.
    task automatic lb_np(input logic [1:0] sp, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BEW-1:0] be, input int outcome);
        bit got_ack = 1'b0, got_rearb = 1'b0, wait_lost = 1'b0;
        int lat;
        exp_q.push_back('{addr: a, data: d, be: be, sp: sp});
        @(negedge clk);
        drive(2'd0, sp, a, d, be);
        @(negedge clk);
        check(lb_wait && !lb_ack, "R6", "wait raised one cycle after request", {lb_wait, lb_ack}, 2'b10);
        for (int i = 0; i < 500; i++) begin
            if (lb_ack || lb_rearb) break;
            if (!lb_wait) wait_lost = 1'b1;
            @(negedge clk);
        end
        got_ack = lb_ack;
        got_rearb = lb_rearb;
        lat = cyc - last_rsp_cyc;
        check(!wait_lost, "R6", "wait held until PCI answer", wait_lost, 0);
        if (outcome == 0)
            check(got_ack && !lb_merr && !got_rearb && lat == 1, "R7", "ack one cycle after response",
                  {got_ack, lb_merr, got_rearb, 8'(lat)}, {3'b100, 8'd1});
        else if (outcome == 1)
            check(got_rearb && !got_ack && !lb_wait && lat == 1, "R8", "rearb one cycle after retry",
                  {got_rearb, got_ack, lb_wait, 8'(lat)}, {3'b100, 8'd1});
        else
            check(got_ack && lb_merr && lat == 1, "R9", "merr on abort",
                  {got_ack, lb_merr, 8'(lat)}, {2'b11, 8'd1});
        drop_req();
        if (got_rearb) begin
            @(negedge clk);
            check(!lb_rearb && !lb_ack, "R8", "rearb is one cycle", {lb_rearb, lb_ack}, 2'b00);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !pci_req && !pci_frame) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check({lb_ack, lb_wait, lb_merr, lb_rearb, pci_req, pci_frame} == 6'b0, "R1", "outputs in reset",
              {lb_ack, lb_wait, lb_merr, lb_rearb, pci_req, pci_frame}, 6'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: posted memory write, request follows the ack
        lb_post(2'd0, 32'h1000_0010, 32'hDEAD_BEEF, 4'hF);
        @(negedge clk);
        check(pci_req, "R2", "pci_req one cycle after ack", pci_req, 1);
        drain();
        lb_post(2'd1, 32'h0000_0CF8, 32'h0000_00A5, 4'b0110);
        drain();

        // R4: retry then disconnect on a posted write re-issues it
        f0 = n_frames;
        rsp_q.push_back(3'd1);
        rsp_q.push_back(3'd2);
        lb_post(2'd0, 32'h2000_0000, 32'h1234_5678, 4'b0001);
        drain();
        check(n_frames - f0 == 3, "R4", "frames for retried posted write", n_frames - f0, 3);

        // R5: abort on posted write frees the entry silently
        f0 = n_frames;
        rsp_q.push_back(3'd3);
        lb_post(2'd0, 32'h3000_0004, 32'h0BAD_0BAD, 4'hF);
        lb_post(2'd1, 32'h3000_0008, 32'h600D_600D, 4'b1100);
        drain();
        check(n_frames - f0 == 2 && exp_q.size() == 0, "R5", "abort frees posted entry",
              {8'(n_frames - f0), 8'(exp_q.size())}, {8'd2, 8'd0});

        // R10: third posted write while buffer full
        hold_gnt = 1'b1;
        lb_post(2'd0, 32'h4000_0000, 32'hAAAA_0001, 4'hF);
        lb_post(2'd0, 32'h4000_0004, 32'hAAAA_0002, 4'hF);
        fork
            lb_post_full(2'd1, 32'h4000_0008, 32'hAAAA_0003, 4'b0011);
            begin
                repeat (6) @(negedge clk);
                check(lb_wait && !lb_ack && pci_req, "R10", "held while full, bus requested",
                      {lb_wait, lb_ack, pci_req}, 3'b101);
                hold_gnt = 1'b0;
            end
        join
        drain();

        // R6: configuration write waits behind a posted write
        hold_gnt = 1'b1;
        lb_post(2'd0, 32'h5000_0000, 32'h5555_0001, 4'hF);
        fork
            lb_np(2'd2, 32'h8000_0800, 32'h5555_0002, 4'hF, 0);
            begin
                repeat (6) @(negedge clk);
                check(!pci_frame && lb_wait && !lb_ack, "R6", "no issue before grant, still waiting",
                      {pci_frame, lb_wait, lb_ack}, 3'b010);
                hold_gnt = 1'b0;
            end
        join
        drain();

        // R7: special cycle answered with disconnect
        rsp_q.push_back(3'd2);
        lb_np(2'd3, 32'h0000_0000, 32'h0000_0042, 4'b0001, 0);
        drain();

        // R8: retry on configuration write -> rearbitrate, then re-request
        rsp_q.push_back(3'd1);
        lb_np(2'd2, 32'h8000_0900, 32'h7777_0000, 4'hF, 1);
        drain();
        lb_np(2'd2, 32'h8000_0900, 32'h7777_0000, 4'hF, 0);
        drain();

        // R9: master and target abort
        rsp_q.push_back(3'd3);
        lb_np(2'd2, 32'h8000_0A00, 32'h9999_0001, 4'hF, 2);
        drain();
        rsp_q.push_back(3'd4);
        lb_np(2'd3, 32'h0000_0000, 32'h9999_0002, 4'b1000, 2);
        drain();

        // R11: burst and line writes ignored
        begin
            bit bad = 1'b0;
            f0 = n_frames;
            @(negedge clk);
            drive(2'd1, 2'd0, 32'h6000_0000, 32'h1111_1111, 4'hF);
            repeat (6) begin
                @(negedge clk);
                if (lb_ack || lb_wait || pci_req || pci_frame) bad = 1'b1;
            end
            drop_req();
            check(!bad, "R11", "burst write ignored", bad, 0);
            @(negedge clk);
            drive(2'd2, 2'd2, 32'h8000_0B00, 32'h2222_2222, 4'hF);
            repeat (6) begin
                @(negedge clk);
                if (lb_ack || lb_wait || pci_req || pci_frame) bad = 1'b1;
            end
            drop_req();
            check(!bad && n_frames == f0, "R11", "line write ignored", {bad, 8'(n_frames - f0)}, 0);
        end

        drain();
        check(exp_q.size() == 0, "R3", "all accepted writes reached PCI", exp_q.size(), 0);
        summary();
    end

endmodule